// File: doc/BRIEF.md
# Isolated I/O Port Decoder

This block sits on a processor bus that keeps I/O in its own address space, separate from memory. It watches the memory-or-I/O and write-or-read status pins together with an active-low cycle strobe, and builds active-low I/O read and I/O write strobes from them. Memory cycles produce neither strobe.

On a decoded I/O write, the block compares only the low eight address bits. It then loads one or both of two byte-wide output registers. The register at the even port sits on the low data byte and is picked by address bit 0 being low. The register at the odd port above it sits on the high data byte and is picked by the active-low high-bank enable. A 16-bit write to the even port with the high bank enabled therefore loads both registers on the same edge.

On a decoded I/O read of the input port, the block places the states of eight switches on the low data byte and raises a drive-enable. In every other cycle the bus is left undriven: the drive-enable is low and the data lines are zero. The reset input is asynchronous and active-low. Its release is synchronised to the clock before the registers see it.

Top module: `io_port_decoder`

## Requirements
- R1: `iorc_n_o` is low exactly when `cyc_n_i`=0, `m_io_i`=0 and `w_r_i`=0. `iowc_n_o` is low exactly when `cyc_n_i`=0, `m_io_i`=0 and `w_r_i`=1. With `m_io_i`=1 (memory) or `cyc_n_i`=1, both strobes stay high.
- R2: Only address bits 7..0 are compared. Bits 19..8 have no effect on any decode, so port 40H also answers at F1240H and input port 48H also answers at ABC48H.
- R3: An I/O write to address 40H (bit 0 = 0) with `bhe_n_i`=1 loads `wdata_i[7:0]` into `lat_lo_o` at the next rising clock edge and leaves `lat_hi_o` unchanged.
- R4: An I/O write to address 41H (bit 0 = 1) with `bhe_n_i`=0 loads `wdata_i[15:8]` into `lat_hi_o` at the next rising edge and leaves `lat_lo_o` unchanged.
- R5: An I/O write to address 40H with `bhe_n_i`=0 loads both registers on the same edge: low byte into `lat_lo_o`, high byte into `lat_hi_o`.
- R6: Both registers hold their value through I/O reads, memory writes, idle cycles and writes to any other port.
- R7: An I/O read of address 48H (bit 0 = 0) sets `rdata_oe_o`=1 and `rdata_o`={8'h00, `sw_i`} in the same cycle, without waiting for a clock edge.
- R8: In every other cycle `rdata_oe_o`=0 and `rdata_o`=16'h0000. This covers unmapped reads, a read of 49H, writes and memory reads.
- R9: `rst_n`=0 clears both registers to 00H at once. After `rst_n` rises, the registers stay cleared through the first two rising edges, and the earliest write is taken on the third edge.
- R10: An I/O write to 41H with `bhe_n_i`=1 enables no byte lane and changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_n_i | input | 1 | Active-low bus cycle strobe |
| m_io_i | input | 1 | Space select: 1 memory, 0 I/O |
| w_r_i | input | 1 | Direction: 1 write, 0 read |
| bhe_n_i | input | 1 | Active-low high byte bank enable |
| addr_i | input | 20 | Bus address |
| wdata_i | input | 16 | Write data bus |
| sw_i | input | 8 | Switch states for the input port |
| iorc_n_o | output | 1 | Active-low I/O read strobe |
| iowc_n_o | output | 1 | Active-low I/O write strobe |
| rdata_o | output | 16 | Read data; zero when not driven |
| rdata_oe_o | output | 1 | Read data drive-enable |
| lat_lo_o | output | 8 | Even-port output register (low byte lane) |
| lat_hi_o | output | 8 | Odd-port output register (high byte lane) |

## Verification
Writes are driven with each lane combination: even port with the high bank off, odd port with the high bank on, even port with the high bank on, and odd port with the high bank off. This separates the single-lane, both-lane and no-lane cases. Aliased addresses with upper bits set show that those bits are ignored. Memory cycles with the same low address show that the status pins gate every strobe. Reads of the input port, of the even output port and of its odd neighbour separate a driven bus from a floating one. A reset applied mid-run, with a write held across its release, shows both the asynchronous clear and the delayed first capture.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int ADDR_W = 20;
  localparam int DEC_W  = 8;
endpackage

// File: rtl/io_rst_sync.sv
module io_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/io_strobe_gen.sv
module io_strobe_gen (
  input  logic cyc_n_i,
  input  logic m_io_i,
  input  logic w_r_i,
  output logic iorc_n_o,
  output logic iowc_n_o
);
  logic io_cyc;

  always_comb begin
    io_cyc   = !cyc_n_i && !m_io_i;
    iorc_n_o = !(io_cyc && !w_r_i);
    iowc_n_o = !(io_cyc &&  w_r_i);
  end

  always_comb begin
    AST_STROBE_EXCL: assert (iorc_n_o || iowc_n_o); // R1
  end
endmodule

// File: rtl/io_port_match.sv
module io_port_match #(
  parameter int          ADDR_W  = 20,
  parameter int          DEC_W   = 8,
  parameter logic [7:0]  WR_PORT = 8'h40,
  parameter logic [7:0]  RD_PORT = 8'h48
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bhe_n_i,
  input  logic              iorc_n_i,
  input  logic              iowc_n_i,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              rd_sel_o
);
  localparam int PAIR_W = DEC_W - 1;
  localparam logic [PAIR_W-1:0] WR_PAIR = WR_PORT[DEC_W-1:1];
  localparam logic [PAIR_W-1:0] RD_PAIR = RD_PORT[DEC_W-1:1];

  logic wr_hit, rd_hit;
  logic unused_upper;

  assign unused_upper = ^addr_i[ADDR_W-1:DEC_W];

  always_comb begin
    wr_hit   = (addr_i[DEC_W-1:1] == WR_PAIR);
    rd_hit   = (addr_i[DEC_W-1:1] == RD_PAIR) && !addr_i[0];
    wr_lo_o  = !iowc_n_i && wr_hit && !addr_i[0];
    wr_hi_o  = !iowc_n_i && wr_hit && !bhe_n_i;
    rd_sel_o = !iorc_n_i && rd_hit;
  end

  always_comb begin
    AST_RD_NEEDS_RC: assert (!rd_sel_o || !iorc_n_i); // R7
  end
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter logic [7:0] WR_PORT = 8'h40,
  parameter logic [7:0] RD_PORT = 8'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_n_i,
  input  logic              m_io_i,
  input  logic              w_r_i,
  input  logic              bhe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] sw_i,
  output logic              iorc_n_o,
  output logic              iowc_n_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic [BYTE_W-1:0] lat_lo_o,
  output logic [BYTE_W-1:0] lat_hi_o
);
  localparam int LANES = DATA_W / BYTE_W;

  logic             rst_sync_n;
  logic             rd_sel;
  logic [LANES-1:0] lane_load;
  logic [BYTE_W-1:0] lane_q [LANES];

  io_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  io_strobe_gen u_strb (
    .cyc_n_i  (cyc_n_i),
    .m_io_i   (m_io_i),
    .w_r_i    (w_r_i),
    .iorc_n_o (iorc_n_o),
    .iowc_n_o (iowc_n_o)
  );

  io_port_match #(
    .ADDR_W  (ADDR_W),
    .DEC_W   (DEC_W),
    .WR_PORT (WR_PORT),
    .RD_PORT (RD_PORT)
  ) u_match (
    .addr_i   (addr_i),
    .bhe_n_i  (bhe_n_i),
    .iorc_n_i (iorc_n_o),
    .iowc_n_i (iowc_n_o),
    .wr_lo_o  (lane_load[0]),
    .wr_hi_o  (lane_load[1]),
    .rd_sel_o (rd_sel)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    io_out_latch #(.W(BYTE_W)) u_lat (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .load_i (lane_load[g]),
      .d_i    (wdata_i[g*BYTE_W +: BYTE_W]),
      .q_o    (lane_q[g])
    );
  end

  assign lat_lo_o = lane_q[0];
  assign lat_hi_o = lane_q[1];

  always_comb begin
    rdata_oe_o = rd_sel;
    rdata_o    = '0;
    if (rd_sel) rdata_o = {{(DATA_W-BYTE_W){1'b0}}, sw_i};
  end

  AST_MEM_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    m_io_i |-> (iorc_n_o && iowc_n_o)); // R1
  AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && lane_load[0]) |=> (lat_lo_o == $past(wdata_i[BYTE_W-1:0]))); // R3
  AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && lane_load[1]) |=> (lat_hi_o == $past(wdata_i[DATA_W-1:BYTE_W]))); // R4
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !lane_load[0]) |=> $stable(lat_lo_o)); // R6
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !lane_load[1]) |=> $stable(lat_hi_o)); // R6
  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rdata_oe_o |-> !iorc_n_o); // R7
  AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rdata_oe_o |-> (rdata_o == '0)); // R8
endmodule

// File: tb/io_port_decoder_tb.sv
module io_port_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic        cyc_n, m_io, w_r, bhe_n;
    logic [19:0] addr;
    logic [15:0] wd;
    logic [7:0]  sw;
    logic        rc, wc, oe;
    logic [15:0] rd;
    logic [7:0]  lo, hi;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,20'h00040,16'hA5C3,8'h00,1'b1,1'b0,1'b0,16'h0000,8'hC3,8'h00,4'd3},  // R3
    '{1'b0,1'b0,1'b1,1'b0,20'h00041,16'h7E11,8'h00,1'b1,1'b0,1'b0,16'h0000,8'hC3,8'h7E,4'd4},  // R4
    '{1'b0,1'b0,1'b1,1'b0,20'h00040,16'h9A5B,8'h00,1'b1,1'b0,1'b0,16'h0000,8'h5B,8'h9A,4'd5},  // R5
    '{1'b0,1'b0,1'b1,1'b1,20'hF1240,16'h0012,8'h00,1'b1,1'b0,1'b0,16'h0000,8'h12,8'h9A,4'd2},  // R2
    '{1'b0,1'b1,1'b1,1'b0,20'h00040,16'hFFFF,8'h00,1'b1,1'b1,1'b0,16'h0000,8'h12,8'h9A,4'd1},  // R1
    '{1'b0,1'b0,1'b1,1'b0,20'h00042,16'h3344,8'h00,1'b1,1'b0,1'b0,16'h0000,8'h12,8'h9A,4'd6},  // R6
    '{1'b0,1'b0,1'b1,1'b1,20'h00041,16'h5566,8'h00,1'b1,1'b0,1'b0,16'h0000,8'h12,8'h9A,4'd10}, // R10
    '{1'b0,1'b0,1'b0,1'b1,20'h00048,16'h0000,8'h5A,1'b0,1'b1,1'b1,16'h005A,8'h12,8'h9A,4'd7},  // R7
    '{1'b0,1'b0,1'b0,1'b1,20'hABC48,16'h0000,8'hC6,1'b0,1'b1,1'b1,16'h00C6,8'h12,8'h9A,4'd2},  // R2
    '{1'b0,1'b0,1'b0,1'b0,20'h00040,16'h0000,8'hFF,1'b0,1'b1,1'b0,16'h0000,8'h12,8'h9A,4'd8},  // R8
    '{1'b0,1'b1,1'b0,1'b1,20'h00048,16'h0000,8'h77,1'b1,1'b1,1'b0,16'h0000,8'h12,8'h9A,4'd8},  // R8
    '{1'b1,1'b0,1'b1,1'b0,20'h00040,16'h1111,8'h00,1'b1,1'b1,1'b0,16'h0000,8'h12,8'h9A,4'd1},  // R1
    '{1'b0,1'b0,1'b0,1'b0,20'h00049,16'h0000,8'h3C,1'b0,1'b1,1'b0,16'h0000,8'h12,8'h9A,4'd8}   // R8
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_n, m_io, w_r, bhe_n;
  logic [19:0] addr;
  logic [15:0] wdata;
  logic [7:0]  sw;
  logic        iorc_n, iowc_n, oe;
  logic [15:0] rdata;
  logic [7:0]  lat_lo, lat_hi;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_port_decoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_n_i    (cyc_n),
    .m_io_i     (m_io),
    .w_r_i      (w_r),
    .bhe_n_i    (bhe_n),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .sw_i       (sw),
    .iorc_n_o   (iorc_n),
    .iowc_n_o   (iowc_n),
    .rdata_o    (rdata),
    .rdata_oe_o (oe),
    .lat_lo_o   (lat_lo),
    .lat_hi_o   (lat_hi)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic m, input logic w, input logic b,
                       input logic [19:0] a, input logic [15:0] d, input logic [7:0] s);
    cyc_n = c; m_io = m; w_r = w; bhe_n = b; addr = a; wdata = d; sw = s;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 20'h0, 16'h0, 8'h0);
    repeat (3) @(negedge clk);
    #1;
    check("R9", "lo in reset", 32'(lat_lo), 32'h00);
    check("R9", "hi in reset", 32'(lat_hi), 32'h00);
    check("R8", "oe idle", 32'(oe), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      drive(VEC[i].cyc_n, VEC[i].m_io, VEC[i].w_r, VEC[i].bhe_n,
            VEC[i].addr, VEC[i].wd, VEC[i].sw);
      #1;
      check(rq, $sformatf("v%0d iorc_n", i), 32'(iorc_n), 32'(VEC[i].rc));
      check(rq, $sformatf("v%0d iowc_n", i), 32'(iowc_n), 32'(VEC[i].wc));
      check(rq, $sformatf("v%0d oe", i),     32'(oe),     32'(VEC[i].oe));
      check(rq, $sformatf("v%0d rdata", i),  32'(rdata),  32'(VEC[i].rd));
      @(negedge clk);
      check(rq, $sformatf("v%0d lo", i), 32'(lat_lo), 32'(VEC[i].lo));
      check(rq, $sformatf("v%0d hi", i), 32'(lat_hi), 32'(VEC[i].hi));
    end

    // R9: asynchronous clear mid-cycle
    drive(1'b1, 1'b0, 1'b1, 1'b1, 20'h0, 16'h0, 8'h0);
    #2;
    rst_n = 1'b0;
    #1;
    check("R9", "lo async clear", 32'(lat_lo), 32'h00);
    check("R9", "hi async clear", 32'(lat_hi), 32'h00);
    // R9: write held across release is ignored until the third edge
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 20'h00040, 16'hBEEF, 8'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "lo after edge 1", 32'(lat_lo), 32'h00);
    @(negedge clk);
    check("R9", "lo after edge 2", 32'(lat_lo), 32'h00);
    @(negedge clk);
    check("R9", "lo after edge 3", 32'(lat_lo), 32'hEF);
    check("R5", "hi after edge 3", 32'(lat_hi), 32'hBE);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 20'h0, 16'h0, 8'h0);
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule